// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the target side of a byte-wide serial memory reached over a two-wire bus. It oversamples the serial clock and data lines with a fast system clock, recognises bus START and STOP events, shifts 8-bit words in on rising clock edges and out after falling edges, and answers each accepted word by pulling the data line low during the ninth clock. It drives the data line open-drain: the block only ever produces an output enable that pulls the pad low.

A transfer opens with a device byte that carries a fixed type pattern, one bit compared with a strap input, the top bit of a 17-bit word address and the transfer direction. A write then takes two more address bytes and any number of data bytes. Every data byte leaves the block as a one-cycle write strobe with its full 17-bit address, for a separate commit block, and the same strobe updates a small behavioural read array that stands in for the storage cells. Reads use an internal address counter, so the master can read from the current address, load an address with an aborted write and then read from it, and keep reading consecutive bytes for as long as it acknowledges. While the commit block reports busy, the slave refuses every device byte.

Top module: `twm_slave`

## Requirements
- R1: A falling data edge while the clock is high (START) restarts device-byte reception from any state, including in the middle of a byte; a rising data edge while the clock is high (STOP) returns the block to idle, after which clocked bytes are not acknowledged until the next START.
- R2: The device byte, most significant bit first, is 1,0,1,0,0, then a bit that must equal `sel_i`, then word-address bit 16, then the direction bit (1 = read); on a match the block pulls SDA low for the whole ninth clock.
- R3: After a device byte that does not match, the block does not drive SDA for the rest of the transfer and acknowledges no further byte.
- R4: While `busy_i` is high, every device byte is answered with no acknowledge.
- R5: In a write, the two bytes after the device byte are acknowledged and form the word address as {bit 16 from the device byte, first byte, second byte}.
- R6: Each write data byte is acknowledged and produces exactly one single-cycle `wr_stb_o` with its address and data; between data bytes only the low 8 address bits count up, wrapping from 0xFF to 0x00 inside the same 256-byte page.
- R7: A read that starts directly with a read device byte returns the byte at one past the last address written or read.
- R8: A write device byte and two address bytes followed by a repeated START and a read device byte return the byte at the loaded address, with no write strobe.
- R9: During a read the block sends the next byte after each master acknowledge; after a master no-acknowledge it stops driving, and SDA is released after the STOP.
- R10: The read address counts through the full 17-bit space and wraps from 0x1FFFF to 0x00000.
- R11: After reset SDA is released, no strobe is pending, the address counter is 0, and the read array entry at index i holds (7*i + 3) mod 256; the array index is the low `MEM_AW` address bits (9 by default).
- R12: SDA is sampled on rising clock edges, and the block changes its own SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sel_i | input | 1 | Strap bit compared with bit 2 of the device byte |
| busy_i | input | 1 | Commit block busy; forces no-acknowledge of device bytes |
| sda_oe_o | output | 1 | 1 pulls the SDA pad low, 0 releases it |
| wr_stb_o | output | 1 | One-cycle strobe per received write data byte |
| wr_addr_o | output | 17 | Word address of the strobed byte |
| wr_data_o | output | 8 | Data of the strobed byte |

## Verification
A corrupted bit counter or phase shows at the pins within one byte time as a missing or misplaced acknowledge, or as SDA pulled low while SCL is high, which would be read as a false START or STOP. A wrong address counter stays hidden until the next read or write strobe, where it shows as a wrong byte or address; the bench therefore reads back every write and checks each strobe address, including page wrap, bit 16 and the top-of-array wrap. Refusals caused by strap mismatch or busy are seen on the very next acknowledge clock.

// File: rtl/twm_pkg.sv
package twm_pkg;

   localparam int BYTE_W = 8;

   // fixed type pattern in the top five bits of the device byte
   localparam logic [4:0] DEV_TYPE = 5'b10100;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEV,
      PH_AHI,
      PH_ALO,
      PH_WDAT,
      PH_RDAT
   } phase_t;

   // reset content of the behavioural read array
   function automatic logic [BYTE_W-1:0] fill_byte(input int idx);
      return BYTE_W'((idx * 7 + 3) % 256);
   endfunction

endpackage

// File: rtl/twm_sync_edge.sv
module twm_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   if (STAGES < 2) begin : g_bad_stages
      $error("twm_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_q, sda_q, scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s    = scl_pipe[STAGES-1];
   assign sda_s    = sda_pipe[STAGES-1];
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twm_addr_ctr.sv
module twm_addr_ctr #(
   parameter int ADDR_W  = 17,
   parameter int PAGE_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step_page,
   input  logic              step_lin,
   output logic [ADDR_W-1:0] cnt
);

   if (PAGE_AW < 1 || PAGE_AW > ADDR_W) begin : g_bad_page
      $error("twm_addr_ctr: PAGE_AW out of range");
   end

   logic [ADDR_W-1:0] page_next;

   if (PAGE_AW == ADDR_W) begin : g_flat
      assign page_next = cnt + ADDR_W'(1);
   end else begin : g_paged
      assign page_next = {cnt[ADDR_W-1:PAGE_AW], cnt[PAGE_AW-1:0] + PAGE_AW'(1)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (load)      cnt <= load_val;
      else if (step_page) cnt <= page_next;
      else if (step_lin)  cnt <= cnt + ADDR_W'(1);
   end

endmodule

// File: rtl/twm_mem.sv
module twm_mem #(
   parameter int MEM_AW = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [MEM_AW-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [MEM_AW-1:0] raddr,
   output logic [7:0]        rdata
);

   localparam int DEPTH = 1 << MEM_AW;

   if (MEM_AW < 1 || MEM_AW > 12) begin : g_bad_depth
      $error("twm_mem: MEM_AW must lie in 1..12");
   end

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= twm_pkg::fill_byte(i);
      end else if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/twm_slave.sv
module twm_slave #(
   parameter int SYNC_STAGES = 2,
   parameter int MEM_AW      = 9,
   parameter int PAGE_AW     = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_i,
   input  logic        sda_i,
   input  logic        sel_i,
   input  logic        busy_i,
   output logic        sda_oe_o,
   output logic        wr_stb_o,
   output logic [16:0] wr_addr_o,
   output logic [7:0]  wr_data_o
);
   import twm_pkg::*;

   localparam int ADDR_W = 2 * BYTE_W + 1;
   localparam int LAST_BIT = BYTE_W - 1;

   if (MEM_AW > ADDR_W) begin : g_bad_mem
      $error("twm_slave: MEM_AW exceeds the word address width");
   end

   logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

   twm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   phase_t            phase, after_ack;
   logic [3:0]        bitcnt;
   logic [7:0]        shreg, hi_byte, rdata;
   logic              oe, page_msb, m_ack;
   logic [ADDR_W-1:0] ctr;

   logic rx_phase, byte_done, ack_end, rd_load, dev_ok;
   logic ctr_load, ctr_step_page;

   assign rx_phase  = (phase == PH_DEV) || (phase == PH_AHI) ||
                      (phase == PH_ALO) || (phase == PH_WDAT);
   assign byte_done = rx_phase && scl_fall && (bitcnt == 4'd8);
   assign ack_end   = rx_phase && scl_fall && (bitcnt == 4'd9);
   assign rd_load   = (ack_end && after_ack == PH_RDAT) ||
                      (phase == PH_RDAT && scl_fall && bitcnt == 4'd8 && m_ack);
   assign dev_ok    = (shreg[7:3] == DEV_TYPE) && (shreg[2] == sel_i) && !busy_i;
   assign ctr_load      = byte_done && (phase == PH_ALO);
   assign ctr_step_page = byte_done && (phase == PH_WDAT);

   twm_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .load(ctr_load), .load_val({page_msb, hi_byte, shreg}),
      .step_page(ctr_step_page), .step_lin(rd_load), .cnt(ctr)
   );

   twm_mem #(.MEM_AW(MEM_AW)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .we(wr_stb_o), .waddr(wr_addr_o[MEM_AW-1:0]), .wdata(wr_data_o),
      .raddr(ctr[MEM_AW-1:0]), .rdata(rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         after_ack <= PH_IDLE;
         bitcnt    <= '0;
         shreg     <= '0;
         hi_byte   <= '0;
         oe        <= 1'b0;
         page_msb  <= 1'b0;
         m_ack     <= 1'b0;
         wr_stb_o  <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_stb_o <= 1'b0;
         if (start_ev) begin
            phase  <= PH_DEV;
            bitcnt <= '0;
            oe     <= 1'b0;
         end else if (stop_ev) begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
            oe     <= 1'b0;
         end else if (phase == PH_RDAT) begin
            if (scl_fall) begin
               if (bitcnt < 4'(LAST_BIT)) begin
                  shreg  <= {shreg[6:0], 1'b0};
                  oe     <= ~shreg[6];
                  bitcnt <= bitcnt + 4'd1;
               end else if (bitcnt == 4'(LAST_BIT)) begin
                  oe     <= 1'b0;
                  bitcnt <= 4'd8;
               end else if (m_ack) begin
                  shreg  <= rdata;
                  oe     <= ~rdata[7];
                  bitcnt <= '0;
               end else begin
                  phase  <= PH_IDLE;
               end
            end else if (scl_rise && bitcnt == 4'd8) begin
               m_ack <= ~sda_s;
            end
         end else if (rx_phase) begin
            if (scl_rise && bitcnt < 4'd8) begin
               shreg  <= {shreg[6:0], sda_s};
               bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
               bitcnt <= 4'd9;
               oe     <= 1'b1;
               case (phase)
                  PH_DEV: begin
                     if (!dev_ok) begin
                        phase  <= PH_IDLE;
                        oe     <= 1'b0;
                        bitcnt <= '0;
                     end else begin
                        page_msb  <= shreg[1];
                        after_ack <= shreg[0] ? PH_RDAT : PH_AHI;
                     end
                  end
                  PH_AHI: begin
                     hi_byte   <= shreg;
                     after_ack <= PH_ALO;
                  end
                  PH_ALO:  after_ack <= PH_WDAT;
                  default: begin
                     wr_stb_o  <= 1'b1;
                     wr_addr_o <= ctr;
                     wr_data_o <= shreg;
                     after_ack <= PH_WDAT;
                  end
               endcase
            end else if (ack_end) begin
               bitcnt <= '0;
               phase  <= after_ack;
               if (after_ack == PH_RDAT) begin
                  shreg <= rdata;
                  oe    <= ~rdata[7];
               end else begin
                  oe    <= 1'b0;
               end
            end
         end
      end
   end

   assign sda_oe_o = oe;

endmodule

// File: rtl/twm_chk.sv
module twm_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe_o,
   input logic wr_stb_o,
   input logic start_ev,
   input logic stop_ev
);

   // R12: own drive moves only while the clock line is low
   p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_i);

   // R1: a START always leaves the line released
   p_start_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> !sda_oe_o);

   // R9: a STOP always leaves the line released
   p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_oe_o);

   // R6: each strobed byte is being acknowledged
   p_strobe_acked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |-> sda_oe_o);

   // R6: strobe lasts one cycle
   p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |=> !wr_stb_o);

endmodule

bind twm_slave twm_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
   .wr_stb_o(wr_stb_o), .start_ev(start_ev), .stop_ev(stop_ev)
);

// File: tb/sim_twm_slave.sv
`timescale 1ns/1ps
module sim_twm_slave;

   localparam int Q = 5;          // quarter SCL period in system clocks
   localparam int MEM_N = 512;

   logic clk = 1'b0, rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1, sel = 1'b1, busy = 1'b0;
   logic bus_sda, sda_oe, wr_stb;
   logic [16:0] wr_addr;
   logic [7:0]  wr_data;

   always #10 clk = ~clk;

   assign bus_sda = m_sda & ~sda_oe;

   twm_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
      .sel_i(sel), .busy_i(busy), .sda_oe_o(sda_oe),
      .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
   );

   int checks = 0, errors = 0, n_stb = 0, viol = 0;
   logic [7:0]  model [MEM_N];
   logic [16:0] stb_a [256];
   logic [7:0]  stb_d [256];
   logic [7:0]  wbuf  [8];
   logic [16:0] mctr = '0;
   logic        prev_oe = 1'b0;

   // strobe capture and drive-timing monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_stb) begin
            stb_a[n_stb & 255] = wr_addr;
            stb_d[n_stb & 255] = wr_data;
            n_stb++;
         end
         if (sda_oe !== prev_oe && m_scl) viol++;
      end
      prev_oe = sda_oe;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b1; tick(2 * Q);
   endtask

   task automatic put_bit(input logic b);
      m_sda = b;    tick(Q);
      m_scl = 1'b1; tick(2 * Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      ack = ~bus_sda;
      tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic get_byte(input logic give_ack, output logic [7:0] b);
      b = '0;
      for (int i = 0; i < 8; i++) begin
         m_sda = 1'b1; tick(Q);
         m_scl = 1'b1; tick(Q);
         b = {b[6:0], bus_sda};
         tick(Q);
         m_scl = 1'b0; tick(Q);
      end
      put_bit(~give_ack);
   endtask

   function automatic logic [7:0] dev_byte(input logic s, input logic p, input logic rd);
      return {5'b10100, s, p, rd};
   endfunction

   task automatic read_body(input int n, input string tag);
      logic [7:0] b;
      for (int k = 0; k < n; k++) begin
         get_byte(k < n - 1, b);
         check(tag, b, model[mctr[8:0]]);
         mctr = mctr + 17'd1;
      end
      bus_stop();
      check("R9 released after stop", sda_oe, 1'b0);
   endtask

   task automatic do_write(input logic [16:0] a, input int n);
      logic ack;
      int s0 = n_stb;
      logic [16:0] ea;
      bus_start();
      send_byte(dev_byte(1'b1, a[16], 1'b0), ack); check("R2 write device ack", ack, 1'b1);
      send_byte(a[15:8], ack); check("R5 high address ack", ack, 1'b1);
      send_byte(a[7:0], ack);  check("R5 low address ack", ack, 1'b1);
      for (int k = 0; k < n; k++) begin
         send_byte(wbuf[k], ack); check("R6 data ack", ack, 1'b1);
      end
      bus_stop();
      check("R6 strobe count", n_stb - s0, n);
      for (int k = 0; k < n; k++) begin
         ea = {a[16:8], a[7:0] + 8'(k)};
         check("R5 R6 strobe address", stb_a[(s0 + k) & 255], ea);
         check("R6 strobe data", stb_d[(s0 + k) & 255], wbuf[k]);
         model[ea[8:0]] = wbuf[k];
      end
      mctr = {a[16:8], a[7:0] + 8'(n)};
   endtask

   task automatic do_read_cur(input int n, input string tag);
      logic ack;
      bus_start();
      send_byte(dev_byte(1'b1, 1'b0, 1'b1), ack); check("R2 read device ack", ack, 1'b1);
      read_body(n, tag);
   endtask

   task automatic do_read_rand(input logic [16:0] a, input int n, input string tag);
      logic ack;
      int s0 = n_stb;
      bus_start();
      send_byte(dev_byte(1'b1, a[16], 1'b0), ack); check("R8 dummy write ack", ack, 1'b1);
      send_byte(a[15:8], ack); check("R8 high address ack", ack, 1'b1);
      send_byte(a[7:0], ack);  check("R8 low address ack", ack, 1'b1);
      bus_start();
      send_byte(dev_byte(1'b1, 1'b0, 1'b1), ack); check("R8 read device ack", ack, 1'b1);
      mctr = a;
      read_body(n, tag);
      check("R8 no strobe in random read", n_stb - s0, 0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic ack;
      logic [16:0] ra;
      int rn;
      void'($urandom(32'd4242));
      for (int i = 0; i < MEM_N; i++) model[i] = 8'((7 * i + 3) % 256);

      tick(4);
      rst_n = 1'b1;
      tick(4);
      check("R11 reset drive", sda_oe, 1'b0);
      check("R11 reset strobe", wr_stb, 1'b0);

      // R7 R11: counter at 0 after reset, two current reads
      do_read_cur(1, "R11 R7 first current read");
      do_read_cur(1, "R7 current read after read");

      // R6: page wrap in a multi-byte write
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
      do_write(17'h012FE, 4);
      do_read_cur(1, "R7 current read after page write");
      do_read_rand(17'h012FE, 2, "R8 R6 read back before wrap");
      do_read_rand(17'h01200, 2, "R8 R6 read back after wrap");

      // R5: bit 16 from the device byte
      wbuf[0] = 8'hC7;
      do_write(17'h10005, 1);
      do_read_rand(17'h10005, 1, "R5 R8 read back bit 16 address");

      // R9: sequential read, R10: wrap of the full address space
      do_read_rand(17'h00040, 5, "R9 sequential read");
      do_read_rand(17'h1FFFE, 4, "R10 read wrap to zero");
      do_read_cur(1, "R10 R7 counter after wrap");

      // R3: strap mismatch, later bytes ignored
      bus_start();
      send_byte(dev_byte(1'b0, 1'b0, 1'b0), ack); check("R3 strap mismatch nack", ack, 1'b0);
      send_byte(8'h00, ack); check("R3 later byte ignored", ack, 1'b0);
      send_byte(8'h5A, ack); check("R3 second byte ignored", ack, 1'b0);
      bus_stop();
      // R2: wrong type pattern
      bus_start();
      send_byte(8'hB3, ack); check("R2 type mismatch nack", ack, 1'b0);
      bus_stop();

      // R4: busy refuses device bytes
      busy = 1'b1;
      bus_start();
      send_byte(dev_byte(1'b1, 1'b0, 1'b1), ack); check("R4 busy read nack", ack, 1'b0);
      bus_stop();
      bus_start();
      send_byte(dev_byte(1'b1, 1'b0, 1'b0), ack); check("R4 busy write nack", ack, 1'b0);
      bus_stop();
      busy = 1'b0;
      do_read_cur(1, "R4 ack again after busy");

      // R1: bytes after STOP without START are ignored
      m_scl = 1'b0; tick(Q);
      send_byte(dev_byte(1'b1, 1'b0, 1'b1), ack); check("R1 no ack without start", ack, 1'b0);
      bus_stop();

      // R1: START in the middle of a byte restarts reception
      bus_start();
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      do_read_cur(2, "R1 read after mid-byte start");

      // random writes read back
      for (int t = 0; t < 14; t++) begin
         ra = 17'($urandom) & 17'h1FFFF;
         rn = 1 + int'($urandom % 3);
         for (int k = 0; k < rn; k++) wbuf[k] = 8'($urandom);
         do_write(ra, rn);
         do_read_rand(ra, 1, "R8 random read back");
         do_read_cur(1, "R7 random next byte");
      end

      check("R12 drive changed only with SCL low", viol, 0);
      finish_run();
   end

endmodule